// File: doc/BRIEF.md
# Repeat-Loop Program Counter Sequencer

This block owns the program counter of a processor that supports zero-overhead repeat blocks. It keeps a loop start address, a loop end address, an iteration count and a small status word. Each time the core retires an instruction (`step` high for one cycle) the block chooses the next PC. A taken branch from the execute stage wins. Otherwise, at the loop end address, control returns to the loop start while the loop is live. In every other case the PC advances by one instruction word of 8 bytes.

After the loop decision, an instruction-address breakpoint can redirect control to a debug trap. A maskable external interrupt is then considered. While masked, it is held in a single pending slot and tried again at every later step. Execution itself happens outside the block. The block sees only the branch result, and a count write when the retiring instruction writes the count register.

Status word bit positions: SM=0, EA=1, DB=2, DS=3, IE=4, RP=5 (RP marks a live repeat block).

Top module: `rpt_pc_seq`

## Requirements
- R1: The loop-back decision uses the count as it stood before the step. A count write made by the retiring instruction (`cnt_wr`) sets the new count but does not change that step's loop-back decision.
- R2: On a step whose PC equals the loop end address, the count drops by one if the old count is nonzero or RP is set. On any other step it is unchanged unless `cnt_wr` writes it.
- R3: On a step where RP was set, the PC equals the loop end address and the resulting count (after the decrement and any `cnt_wr`) is zero, RP is cleared. RP is otherwise set only by a configuration or status write.
- R4: Next PC, in priority order: `br_target` when `br_valid`; else the loop start when RP was set, the old count was nonzero and the PC equals the loop end; else PC + 8.
- R5: When the stepping PC equals `bp_addr` and DB is set, the following happen. `dbg_pc` takes the next PC chosen by R4. `dbg_status` takes the status after the loop update with EA (bit 1) set. The status becomes SM kept, DS (bit 3) set and all other bits zero. The PC becomes 0xFFFFF128. With DB clear, no trap occurs.
- R6: The breakpoint is evaluated after the loop update. The count decrement and the loop-back target recorded in `dbg_pc` are the same as if no breakpoint had hit.
- R7: On a step where a request is present (`irq_req` or the pending slot) and IE (bit 4) is set in the status that follows the breakpoint check, the following happen. `bk_pc` and `bk_status` take that PC and status. The status clears to zero and the PC becomes 0xFFFFF138.
- R8: A request that is masked, or that arrives between steps, sets the single pending slot. Further requests while the slot is full are discarded, so only one delivery results.
- R9: A delivery clears the pending slot. Because a breakpoint trap clears IE, a request that coincides with a breakpoint hit is left pending rather than delivered.
- R10: Reset gives PC = 0, count = 0, status = 0 and no pending request. A configuration write (outside a step) loads start, end and count and sets RP. A status write (outside a step) replaces the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction retires this cycle |
| br_valid | input | 1 | Retiring instruction produced a branch target |
| br_target | input | 32 | Branch target address |
| cnt_wr | input | 1 | Retiring instruction writes the count |
| cnt_wdata | input | 16 | Count value written by the retiring instruction |
| cfg_we | input | 1 | Load loop start, end and count and set RP (ignored during a step) |
| cfg_start | input | 32 | Loop start address |
| cfg_end | input | 32 | Loop end address |
| cfg_count | input | 16 | Loop count |
| sw_we | input | 1 | Status word write (ignored during a step) |
| sw_wdata | input | 6 | Status word write value |
| bp_addr | input | 32 | Instruction breakpoint address |
| irq_req | input | 1 | External interrupt request |
| pc | output | 32 | Current program counter |
| rpt_count | output | 16 | Loop count |
| status | output | 6 | Status word |
| dbg_pc | output | 32 | PC saved by the debug trap |
| dbg_status | output | 6 | Status saved by the debug trap |
| bk_pc | output | 32 | PC saved by interrupt delivery |
| bk_status | output | 6 | Status saved by interrupt delivery |
| irq_pending | output | 1 | Pending interrupt slot |

## Verification
The hardest case to reach is a single step where several rules collide: the loop end, a count write by the retiring instruction, a breakpoint hit and an interrupt request all land on the same step. The stimulus gets there in three moves. It places loops so that a branch lands exactly on the end address, it issues count writes on that end step, and it arms DB with `bp_addr` equal to the loop end. A request presented together with a breakpoint hit then shows that the trap clears IE first and leaves the request pending. Repeated masked requests followed by an unmask show that exactly one delivery comes out of the single slot.

// File: rtl/rpt_pc_seq.sv
module rpt_pc_seq #(
  parameter int          AW       = 32,
  parameter int          CW       = 16,
  parameter int          STEP     = 8,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [31:0] DBG_VEC  = 32'hFFFF_F128,
  parameter logic [31:0] IRQ_VEC  = 32'hFFFF_F138
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          br_valid,
  input  logic [AW-1:0] br_target,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic [CW-1:0] cfg_count,
  input  logic          sw_we,
  input  logic [5:0]    sw_wdata,
  input  logic [AW-1:0] bp_addr,
  input  logic          irq_req,
  output logic [AW-1:0] pc,
  output logic [CW-1:0] rpt_count,
  output logic [5:0]    status,
  output logic [AW-1:0] dbg_pc,
  output logic [5:0]    dbg_status,
  output logic [AW-1:0] bk_pc,
  output logic [5:0]    bk_status,
  output logic          irq_pending
);
  localparam int B_SM = 0, B_EA = 1, B_DB = 2, B_DS = 3, B_IE = 4, B_RP = 5;
  localparam logic [5:0] M_SM = 6'(1) << B_SM;
  localparam logic [5:0] M_EA = 6'(1) << B_EA;
  localparam logic [5:0] M_DS = 6'(1) << B_DS;

  logic [AW-1:0] start_q, end_q;
  logic [5:0]    st_loop, st_bp;

  wire at_end  = (pc == end_q);
  wire cnt_nz  = (rpt_count != '0);
  wire rp_was  = status[B_RP];
  wire dec     = at_end && (cnt_nz || rp_was);
  wire [CW-1:0] cnt_dec = rpt_count - {{(CW-1){1'b0}}, dec};
  wire [CW-1:0] cnt_new = cnt_wr ? cnt_wdata : cnt_dec;
  wire loop_back = rp_was && cnt_nz && at_end;

  wire [AW-1:0] seq_pc = br_valid  ? br_target :
                         loop_back ? start_q   : pc + AW'(STEP);

  always_comb begin
    st_loop = status;
    if (rp_was && at_end && cnt_new == '0) st_loop[B_RP] = 1'b0;
  end

  wire bp_hit = (pc == bp_addr) && status[B_DB];
  always_comb st_bp = bp_hit ? ((status & M_SM) | M_DS) : st_loop;
  wire [AW-1:0] pc_bp = bp_hit ? AW'(DBG_VEC) : seq_pc;

  wire irq_any = irq_req || irq_pending;
  wire irq_go  = irq_any && st_bp[B_IE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= AW'(RESET_PC);
      start_q     <= '0;
      end_q       <= '0;
      rpt_count   <= '0;
      status      <= '0;
      dbg_pc      <= '0;
      dbg_status  <= '0;
      bk_pc       <= '0;
      bk_status   <= '0;
      irq_pending <= 1'b0;
    end else if (step) begin
      rpt_count   <= cnt_new;
      pc          <= irq_go ? AW'(IRQ_VEC) : pc_bp;
      status      <= irq_go ? 6'b0 : st_bp;
      irq_pending <= irq_any && !irq_go;
      if (bp_hit) begin
        dbg_pc     <= seq_pc;
        dbg_status <= st_loop | M_EA;
      end
      if (irq_go) begin
        bk_pc     <= pc_bp;
        bk_status <= st_bp;
      end
    end else begin
      irq_pending <= irq_pending || irq_req;
      if (sw_we) status <= sw_wdata;
      if (cfg_we) begin
        start_q        <= cfg_start;
        end_q          <= cfg_end;
        rpt_count      <= cfg_count;
        status[B_RP]   <= 1'b1;
      end
    end
  end

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !cnt_wr |=> rpt_count <= $past(rpt_count)) else $error("count rose"); // R2
  AST_RP_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !status[B_RP] && !(cfg_we && !step) && !(sw_we && !step) |=> !status[B_RP]) else $error("RP set"); // R3
  AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    step && br_valid && !bp_hit && !irq_go |=> pc == $past(br_target)) else $error("branch lost"); // R4
  AST_DBG_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && bp_hit |=> pc == AW'(DBG_VEC) && status[B_DS] && !status[B_IE]) else $error("bp trap"); // R5
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    step && irq_go |=> pc == AW'(IRQ_VEC) && status == 6'b0 && !irq_pending) else $error("irq entry"); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending && !step |=> irq_pending) else $error("pending lost"); // R8
endmodule

// File: tb/tb_rpt_pc_seq.sv
module tb_rpt_pc_seq;
  logic clk = 0, rst_n = 0, step = 0, br_valid = 0, cnt_wr = 0, cfg_we = 0, sw_we = 0, irq_req = 0;
  logic [31:0] br_target = 0, cfg_start = 0, cfg_end = 0, bp_addr = 32'hFFFF_0000;
  logic [15:0] cnt_wdata = 0, cfg_count = 0;
  logic [5:0]  sw_wdata = 0;
  logic [31:0] pc, dbg_pc, bk_pc;
  logic [15:0] rpt_count;
  logic [5:0]  status, dbg_status, bk_status;
  logic        irq_pending;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  localparam logic [31:0] DVEC = 32'hFFFF_F128, IVEC = 32'hFFFF_F138;

  rpt_pc_seq dut (.clk, .rst_n, .step, .br_valid, .br_target, .cnt_wr, .cnt_wdata,
    .cfg_we, .cfg_start, .cfg_end, .cfg_count, .sw_we, .sw_wdata, .bp_addr, .irq_req,
    .pc, .rpt_count, .status, .dbg_pc, .dbg_status, .bk_pc, .bk_status, .irq_pending);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stp(bit bv = 0, logic [31:0] bt = 0, bit cw = 0, logic [15:0] cv = 0, bit irq = 0);
    @(negedge clk);
    step = 1; br_valid = bv; br_target = bt; cnt_wr = cw; cnt_wdata = cv; irq_req = irq;
    @(negedge clk);
    step = 0; br_valid = 0; cnt_wr = 0; irq_req = 0;
  endtask

  task automatic cfg(logic [31:0] s, logic [31:0] e, logic [15:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_start = s; cfg_end = e; cfg_count = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic sw(logic [5:0] v);
    @(negedge clk);
    sw_we = 1; sw_wdata = v;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq_req = 1;
    @(negedge clk);
    irq_req = 0;
  endtask

  task automatic t_reset();
    chk("R10 pc", pc, 0);
    chk("R10 count", 32'(rpt_count), 0);
    chk("R10 status", 32'(status), 0);
    chk("R10 pending", 32'(irq_pending), 0);
  endtask

  task automatic t_loop();
    cfg(32'h100, 32'h110, 2);
    chk("R10 cfg count", 32'(rpt_count), 2);
    chk("R10 cfg RP", 32'(status[5]), 1);
    stp(1, 32'h100);
    chk("R4 branch", pc, 32'h100);
    stp(); stp();
    chk("R4 seq", pc, 32'h110);
    stp();
    chk("R4 loop back", pc, 32'h100);
    chk("R2 dec", 32'(rpt_count), 1);
    stp(); stp(); stp();
    chk("R4 loop back last", pc, 32'h100);
    chk("R2 dec to zero", 32'(rpt_count), 0);
    chk("R3 RP cleared", 32'(status[5]), 0);
    stp(); stp(); stp();
    chk("R4 fall through", pc, 32'h118);
    chk("R2 no dec when idle", 32'(rpt_count), 0);
  endtask

  task automatic t_exwrite();
    cfg(32'h200, 32'h208, 1);
    stp(1, 32'h208);
    stp(0, 0, 1, 16'd5);
    chk("R1 loop back with write", pc, 32'h200);
    chk("R1 count written", 32'(rpt_count), 5);
    chk("R3 RP kept", 32'(status[5]), 1);
    stp();
    stp(0, 0, 1, 16'd0);
    chk("R1 sampled count loops", pc, 32'h200);
    chk("R3 RP cleared by write", 32'(status[5]), 0);
  endtask

  task automatic t_branch();
    cfg(32'h300, 32'h310, 3);
    stp(1, 32'h310);
    stp(1, 32'h500);
    chk("R4 branch beats loop", pc, 32'h500);
    chk("R2 dec under branch", 32'(rpt_count), 2);
  endtask

  task automatic t_bp();
    cfg(32'h400, 32'h408, 2);
    sw(6'h25);
    bp_addr = 32'h408;
    stp(1, 32'h408);
    stp();
    chk("R5 trap pc", pc, DVEC);
    chk("R6 dbg_pc loop target", dbg_pc, 32'h400);
    chk("R5 dbg_status", 32'(dbg_status), 32'h27);
    chk("R5 status", 32'(status), 32'h09);
    chk("R6 count decremented", 32'(rpt_count), 1);
    sw(6'h00);
    bp_addr = DVEC;
    stp();
    chk("R5 DB clear no trap", pc, DVEC + 8);
    chk("R5 dbg_pc kept", dbg_pc, 32'h400);
  endtask

  task automatic t_irq();
    stp(1, 32'h600);
    sw(6'h10);
    stp(0, 0, 0, 0, 1);
    chk("R7 vector", pc, IVEC);
    chk("R7 bk_pc", bk_pc, 32'h608);
    chk("R7 bk_status", 32'(bk_status), 32'h10);
    chk("R7 status cleared", 32'(status), 0);
  endtask

  task automatic t_pend();
    pulse_irq();
    chk("R8 pending set", 32'(irq_pending), 1);
    pulse_irq();
    stp();
    chk("R8 masked no delivery", pc, IVEC + 8);
    chk("R8 still pending", 32'(irq_pending), 1);
    sw(6'h10);
    stp();
    chk("R9 delivered", pc, IVEC);
    chk("R9 bk_pc", bk_pc, IVEC + 16);
    chk("R9 pending cleared", 32'(irq_pending), 0);
    sw(6'h10);
    stp();
    chk("R8 second discarded", pc, IVEC + 8);
  endtask

  task automatic t_bp_irq();
    sw(6'h14);
    bp_addr = IVEC + 8;
    stp(0, 0, 0, 0, 1);
    chk("R9 bp first", pc, DVEC);
    chk("R9 left pending", 32'(irq_pending), 1);
    chk("R5 dbg_status no SM", 32'(dbg_status), 32'h16);
    chk("R5 status DS only", 32'(status), 32'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_loop();
    t_exwrite();
    t_branch();
    t_bp();
    t_irq();
    t_pend();
    t_bp_irq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule